// File: doc/BRIEF.md
# OTG Session Request Initiator

This block is the B-device side of the OTG session request procedure. When a start request arrives and the bus is dormant, it first pulses the local data-line pull-up and then pulses a VBUS charge current. It can then drain VBUS for a fixed time. The sequence ends with a one-cycle `done`, or with a one-cycle `err` if the request is refused, aborted or runs past its deadline. All timing is counted in ticks of an external one-millisecond strobe.

The pull-up and charge durations are programmed in millisecond units on `line_ms` and `chrg_ms`. Each is clamped into its legal window and captured when a start is accepted. The discharge tail is chosen by `drain_sel`, which is also captured at acceptance. The analog comparators, the transceiver and the A-device's response sit outside this block.

Top module: `srp_initiator`

## Requirements
- R1: A start is accepted only if, in that cycle, `id_b`=1 (B-device), `sess_end`=1 (VBUS below session end), and `se0`=1 with at least SE0_MIN_MS (default 2) `ms_tick` pulses seen since `se0` last went high. On acceptance `line_en` and `busy` are high from the next cycle.
- R2: A start that fails R1 produces `err`=1 for exactly the next cycle, and `busy`, `line_en`, `chrg_en` and `drain_en` stay low.
- R3: `line_en` stays high for exactly the captured line duration in ticks. `chrg_en` rises on the same edge where `line_en` falls, and the two are never high together.
- R4: The line duration is `line_ms` clamped to the range 5..10.
- R5: The charge duration is `chrg_ms` clamped to the range 10..20. After it, `chrg_en` falls.
- R6: If `drain_sel` was 1 at acceptance, `drain_en` is high for DRAIN_MS (default 30) ticks after charging ends. If it was 0, the sequence ends when charging ends.
- R7: `chrg_en` and `drain_en` are never high in the same cycle.
- R8: If the charge phase has not finished by the DEADLINE_MS-th tick after acceptance (default 100), the sequence stops. All outputs go low and `err` pulses for one cycle, with no `done`.
- R9: `done` is a one-cycle pulse at completion. `busy` is high from acceptance up to, and low in, the cycle where `done` or `err` is high.
- R10: `abort`=1 while busy drops every drive output and `busy` in the next cycle and pulses `err`. No `done` follows.
- R11: A start while busy is ignored: phase lengths are unchanged and no `err` is raised.
- R12: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| start | input | 1 | Request to begin a session request |
| abort | input | 1 | Stop a running sequence |
| id_b | input | 1 | ID pin reads B-device |
| sess_end | input | 1 | VBUS below session-end threshold |
| se0 | input | 1 | Line state is SE0 |
| drain_sel | input | 1 | Append discharge tail |
| line_ms | input | CNT_W | Requested pull-up duration (ms) |
| chrg_ms | input | CNT_W | Requested charge duration (ms) |
| line_en | output | 1 | Data-line pull-up enable |
| chrg_en | output | 1 | VBUS charge enable |
| drain_en | output | 1 | VBUS discharge enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Refusal, abort or deadline pulse |

## Verification
The assertions check the per-cycle invariants on every cycle. These are the mutual exclusion of the drive outputs, the handover from pull-up to charge, the shape of `done` and `err`, the idle state after an abort, and that a rising pull-up follows a start whose preconditions held. Only the bench's scenarios can show the tick counts of each phase, the clamping of out-of-window durations, the presence or absence of the discharge tail, the deadline cut-off and the qualification of SE0 time. Each of these depends on values captured many cycles earlier.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LINE  = 2'd1,
    ST_CHRG  = 2'd2,
    ST_DRAIN = 2'd3
  } srp_state_t;
endpackage

// File: rtl/srp_window_clamp.sv
module srp_window_clamp #(
  parameter int W  = 8,
  parameter int LO = 5,
  parameter int HI = 10
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_comb begin
    if (raw < LO_V)      val = LO_V;
    else if (raw > HI_V) val = HI_V;
    else                 val = raw;
  end
endmodule

// File: rtl/srp_tick_timer.sv
module srp_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + {{(W-1){1'b0}}, 1'b1};
  assign hit     = en && (cnt_inc == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/srp_se0_qual.sv
module srp_se0_qual #(
  parameter int MIN_MS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  input  logic ms_tick,
  output logic ok
);
  localparam int QW = $clog2(MIN_MS + 1);
  localparam logic [QW-1:0] TOP = QW'(MIN_MS);

  logic [QW-1:0] cnt_q, cnt_d;

  assign ok = se0 && (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (!se0)                         cnt_d = '0;
    else if (ms_tick && cnt_q != TOP) cnt_d = cnt_q + {{(QW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/srp_initiator.sv
module srp_initiator
  import srp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int LINE_MIN    = 5,
  parameter int LINE_MAX    = 10,
  parameter int CHRG_MIN    = 10,
  parameter int CHRG_MAX    = 20,
  parameter int DRAIN_MS    = 30,
  parameter int DEADLINE_MS = 100,
  parameter int SE0_MIN_MS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             start,
  input  logic             abort,
  input  logic             id_b,
  input  logic             sess_end,
  input  logic             se0,
  input  logic             drain_sel,
  input  logic [CNT_W-1:0] line_ms,
  input  logic [CNT_W-1:0] chrg_ms,
  output logic             line_en,
  output logic             chrg_en,
  output logic             drain_en,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int ELW = $clog2(DEADLINE_MS + 1);
  localparam logic [ELW-1:0]   DL_V    = ELW'(DEADLINE_MS);
  localparam logic [CNT_W-1:0] DRAIN_V = CNT_W'(DRAIN_MS);

  srp_state_t       st_q, st_d;
  logic [CNT_W-1:0] line_len_q, chrg_len_q, line_cl, chrg_cl, ph_limit;
  logic             drain_q, se0_ok, pre_ok, accept;
  logic             ph_clr, ph_hit, el_hit, done_d, err_d;

  srp_window_clamp #(.W(CNT_W), .LO(LINE_MIN), .HI(LINE_MAX)) u_line_cl (
    .raw(line_ms), .val(line_cl));
  srp_window_clamp #(.W(CNT_W), .LO(CHRG_MIN), .HI(CHRG_MAX)) u_chrg_cl (
    .raw(chrg_ms), .val(chrg_cl));

  srp_se0_qual #(.MIN_MS(SE0_MIN_MS)) u_se0 (
    .clk(clk), .rst_n(rst_n), .se0(se0), .ms_tick(ms_tick), .ok(se0_ok));

  assign pre_ok = id_b && sess_end && se0_ok;
  assign accept = (st_q == ST_IDLE) && start && pre_ok;

  always_comb begin
    case (st_q)
      ST_LINE: ph_limit = line_len_q;
      ST_CHRG: ph_limit = chrg_len_q;
      default: ph_limit = DRAIN_V;
    endcase
  end

  srp_tick_timer #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr),
    .en(ms_tick && (st_q != ST_IDLE)), .limit(ph_limit), .hit(ph_hit));

  srp_tick_timer #(.W(ELW)) u_elapsed (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .en(ms_tick && (st_q == ST_LINE || st_q == ST_CHRG)),
    .limit(DL_V), .hit(el_hit));

  always_comb begin
    st_d   = st_q;
    ph_clr = 1'b0;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (pre_ok) begin
            st_d   = ST_LINE;
            ph_clr = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_LINE: begin
        if (abort || el_hit) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end else if (ph_hit) begin
          st_d   = ST_CHRG;
          ph_clr = 1'b1;
        end
      end
      ST_CHRG: begin
        if (abort) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end else if (ph_hit) begin
          ph_clr = 1'b1;
          if (drain_q) begin
            st_d = ST_DRAIN;
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end else if (el_hit) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end
      end
      default: begin
        if (abort) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end else if (ph_hit) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
      err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_len_q <= '0;
      chrg_len_q <= '0;
      drain_q    <= 1'b0;
    end else if (accept) begin
      line_len_q <= line_cl;
      chrg_len_q <= chrg_cl;
      drain_q    <= drain_sel;
    end
  end

  assign line_en  = (st_q == ST_LINE);
  assign chrg_en  = (st_q == ST_CHRG);
  assign drain_en = (st_q == ST_DRAIN);
  assign busy     = (st_q != ST_IDLE);
endmodule

// File: rtl/srp_initiator_chk.sv
module srp_initiator_chk (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic start,
  input logic abort,
  input logic id_b,
  input logic sess_end,
  input logic se0,
  input logic line_en,
  input logic chrg_en,
  input logic drain_en,
  input logic busy,
  input logic done,
  input logic err
);
  // R7
  a_r7_no_chrg_drain: assert property (@(posedge clk) disable iff (!rst_n)
    !(chrg_en && drain_en));
  // R3
  a_r3_line_chrg_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_en && chrg_en));
  a_r3_chrg_after_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrg_en) |-> $past(line_en));
  // R1
  a_r1_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_en) |-> ($past(start) && $past(id_b) && $past(sess_end) && $past(se0)));
  // R9
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));
  // R2 / R8
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!line_en && !chrg_en && !drain_en && !busy));
  a_r2_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R10
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (!busy && err && !done));
endmodule

bind srp_initiator srp_initiator_chk chk_i (.*);

// File: tb/srp_initiator_tb_top.sv
module srp_initiator_tb_top;
  logic clk = 1'b0;
  logic rst_n, ms_tick, start, abort, id_b, sess_end, se0, drain_sel;
  logic [7:0] line_ms, chrg_ms;
  logic line_en, chrg_en, drain_en, busy, done, err;
  logic l2, c2, d2, b2, dn2, e2;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  srp_initiator dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start(start), .abort(abort),
    .id_b(id_b), .sess_end(sess_end), .se0(se0), .drain_sel(drain_sel),
    .line_ms(line_ms), .chrg_ms(chrg_ms), .line_en(line_en), .chrg_en(chrg_en),
    .drain_en(drain_en), .busy(busy), .done(done), .err(err));

  // short-deadline copy for R8
  srp_initiator #(.DEADLINE_MS(20)) dut_dl (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start(start), .abort(abort),
    .id_b(id_b), .sess_end(sess_end), .se0(se0), .drain_sel(drain_sel),
    .line_ms(line_ms), .chrg_ms(chrg_ms), .line_en(l2), .chrg_en(c2),
    .drain_en(d2), .busy(b2), .done(dn2), .err(e2));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic tk);
    ms_tick = tk;
    @(posedge clk);
    #2;
    ms_tick = 1'b0;
    start   = 1'b0;
    abort   = 1'b0;
  endtask

  // {line_ms, chrg_ms, drain_sel, exp_line, exp_chrg, exp_drain}
  localparam logic [40:0] VEC [7] = '{
    {8'd7,  8'd15, 1'b0, 8'd7,  8'd15, 8'd0},
    {8'd2,  8'd3,  1'b1, 8'd5,  8'd10, 8'd30},
    {8'd50, 8'd99, 1'b0, 8'd10, 8'd20, 8'd0},
    {8'd5,  8'd10, 1'b1, 8'd5,  8'd10, 8'd30},
    {8'd10, 8'd20, 1'b0, 8'd10, 8'd20, 8'd0},
    {8'd0,  8'd0,  1'b0, 8'd5,  8'd10, 8'd0},
    {8'd9,  8'd11, 1'b1, 8'd9,  8'd11, 8'd30}
  };

  int t_line, t_chrg, t_drain, t_dl;
  logic saw_done, saw_err, dl_err, dl_done;

  task automatic run_seq(input logic [7:0] lm, input logic [7:0] cm,
                         input logic ds, input logic restart);
    logic pu, ch, dc, bz2, prev_pu;
    t_line = 0; t_chrg = 0; t_drain = 0; t_dl = 0;
    saw_done = 0; saw_err = 0; dl_err = 0; dl_done = 0;
    line_ms = lm; chrg_ms = cm; drain_sel = ds;
    start = 1'b1;
    step(1'b0);
    check("R1 accepted line_en", int'(line_en), 1);
    check("R9 busy after accept", int'(busy), 1);
    prev_pu = line_en;
    for (int i = 0; i < 400; i++) begin
      logic tk;
      tk = (i % 4 == 3);
      pu = line_en; ch = chrg_en; dc = drain_en; bz2 = b2;
      if (tk && pu) t_line++;
      if (tk && ch) t_chrg++;
      if (tk && dc) t_drain++;
      if (tk && bz2) t_dl++;
      if (restart && i == 10) begin
        line_ms = 8'd99; chrg_ms = 8'd99; drain_sel = ~ds; start = 1'b1;
      end
      step(tk);
      if (e2) dl_err = 1;
      if (dn2) dl_done = 1;
      if (err) saw_err = 1;
      if (prev_pu && !line_en)
        check("R3 charge starts as pull-up ends", int'(chrg_en), 1);
      prev_pu = line_en;
      if (done) begin
        saw_done = 1;
        check("R9 busy low with done", int'(busy), 0);
        step(1'b0);
        check("R9 done lasts one cycle", int'(done), 0);
        break;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; ms_tick = 0; start = 0; abort = 0; id_b = 0; sess_end = 0;
    se0 = 0; drain_sel = 0; line_ms = 0; chrg_ms = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R12 reset line_en", int'(line_en), 0);
    check("R12 reset chrg_en", int'(chrg_en), 0);
    check("R12 reset drain_en", int'(drain_en), 0);
    check("R12 reset busy/done/err", int'({busy, done, err}), 0);
    rst_n = 1'b1;
    id_b = 1; sess_end = 1; se0 = 1;
    step(1); step(0); step(1); step(0);

    // vector table: R3 R4 R5 R6 R9
    for (int v = 0; v < 7; v++) begin
      logic [40:0] e;
      e = VEC[v];
      run_seq(e[40:33], e[32:25], e[24], 1'b0);
      check("R4 line duration", t_line, int'(e[23:16]));
      check("R5 charge duration", t_chrg, int'(e[15:8]));
      check("R6 discharge duration", t_drain, int'(e[7:0]));
      check("R9 done seen", int'(saw_done), 1);
    end

    // R8 deadline on the short-deadline copy; default copy finishes
    run_seq(8'd10, 8'd20, 1'b0, 1'b0);
    check("R8 deadline err", int'(dl_err), 1);
    check("R8 no done after deadline", int'(dl_done), 0);
    check("R8 ticks until cut-off", t_dl, 20);
    check("R8 default deadline not hit", int'(saw_err), 0);

    // R11 start while busy ignored
    run_seq(8'd6, 8'd12, 1'b0, 1'b1);
    check("R11 line unchanged", t_line, 6);
    check("R11 charge unchanged", t_chrg, 12);
    check("R11 no drain", t_drain, 0);
    check("R11 no err", int'(saw_err), 0);

    // R1 / R2 refusals
    id_b = 0; start = 1; step(0);
    check("R2 err on A-device id", int'(err), 1);
    check("R2 idle on refusal", int'({busy, line_en}), 0);
    step(0);
    check("R2 err one cycle", int'(err), 0);
    id_b = 1; sess_end = 0; start = 1; step(0);
    check("R1 refused when VBUS valid", int'({busy, err}), 1);
    sess_end = 1;
    se0 = 0; step(0); se0 = 1; step(1);
    start = 1; step(0);
    check("R1 refused after one SE0 ms", int'({busy, err}), 1);
    step(1);
    start = 1; step(0);
    check("R1 accepted after two SE0 ms", int'({busy, err}), 2);

    // R10 abort in pull-up phase
    abort = 1; step(0);
    check("R10 abort releases", int'({line_en, chrg_en, drain_en, busy}), 0);
    check("R10 abort err", int'(err), 1);
    step(0);
    check("R10 no done", int'(done), 0);

    // R10 abort in charge phase
    line_ms = 5; chrg_ms = 10; drain_sel = 0;
    start = 1; step(0);
    for (int k = 0; k < 5; k++) step(1);
    check("R10 in charge phase", int'(chrg_en), 1);
    abort = 1; step(0);
    check("R10 charge abort releases", int'({chrg_en, busy, err}), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule